// File: doc/BRIEF.md
# Trigger/Busy Handshake Serializer

This block drives the trigger side of a two-wire handshake with one device under test. The device may run on a clock that is unrelated to the block's clock. The block takes a one-cycle trigger request from upstream trigger logic and raises the trigger line. It then ignores every further request until the device has raised its busy line and dropped it again. Both remote inputs, the busy line and the device's readout clock, pass through multi-stage synchronizers before any logic uses them.

In readout mode the trigger line also carries serial data. The trigger line is first lowered in answer to busy. After that, every change of level on the device's readout clock, rising or falling, places the next bit of the trigger number on the trigger line, least significant bit first. The trigger number counts the requests accepted since reset, and the value sent is the one captured when that trigger was issued. When the number has been fully sent, further readout clock changes give zero. A mode input chooses between the plain handshake and the handshake with readout. The block samples it only when it accepts a trigger.

Top module: `trig_busy_serializer`

## Requirements
- R1: After a synchronous reset, trig_line and veto are low and the trigger number restarts, so the first trigger accepted after reset carries number 1.
- R2: A one-cycle trig_req while veto is low makes trig_line and veto high on the next clock edge.
- R3: While veto is high, trig_req pulses are ignored: trig_line does not change because of them and the trigger number does not advance.
- R4: trig_line stays high until the synchronized busy_in is seen high, and then goes low. In plain mode it stays low for the rest of the handshake, whatever dclk_in does.
- R5: veto stays high while the synchronized busy_in is high and goes low, together with trig_line, once busy_in is seen low. A new trigger can then be accepted.
- R6: In readout mode, after trig_line has been lowered and while busy_in is high, each change of level on dclk_in (either direction) puts the next trigger number bit on trig_line, starting with bit 0.
- R7: The number sent for a trigger equals the count of triggers accepted since reset, including that trigger. The width is NUM_W bits, 32 by default.
- R8: Once all NUM_W bits have been sent, every further dclk_in change drives trig_line to 0.
- R9: dclk_in changes that occur while trig_line is still high are ignored: they shift nothing, and the first bit sent afterwards is still bit 0.
- R10: readout_en is sampled only when a trigger is accepted. Changing it during a handshake has no effect on that handshake.
- R11: If busy_in falls before all bits have been sent, the unsent bits are discarded. The readout for the next trigger starts again at bit 0 of its own number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_req | input | 1 | One-cycle trigger request from upstream logic |
| readout_en | input | 1 | 1 selects handshake with number readout, 0 selects plain handshake |
| busy_in | input | 1 | Busy line from the device, asynchronous |
| dclk_in | input | 1 | Readout clock from the device, asynchronous |
| trig_line | output | 1 | Trigger line to the device; carries number bits during readout |
| veto | output | 1 | High while a handshake is in progress and requests are ignored |

## Verification
The bench sends extra requests in both the raised-trigger phase and the busy phase. A design that leaked them would skip trigger numbers or re-raise the line. It toggles the readout clock before busy arrives, where a design that shifted too early would lose bit 0. It reads past the last bit, where a design that rotated rather than drained would repeat the number. It also drops busy in the middle of a readout and then checks that the next number starts cleanly at its LSB. Finally, it flips the mode during a handshake to catch a design that decodes the live mode input instead of the value captured at acceptance.

// File: rtl/tbh_pkg.sv
package tbh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RAISED = 2'd1,
    ST_HOLD   = 2'd2
  } hs_state_t;
endpackage

// File: rtl/tbh_sync.sv
module tbh_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tbh_toggle_det.sv
module tbh_toggle_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic toggle
);
  logic lvl;
  logic lvl_prev;

  tbh_sync #(.STAGES(STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (async_in),
    .q   (lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) lvl_prev <= 1'b0;
    else     lvl_prev <= lvl;
  end

  assign toggle = lvl ^ lvl_prev;
endmodule

// File: rtl/tbh_shifter.sv
module tbh_shifter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         head
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0] sreg;
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      left <= '0;
    end else if (load) begin
      sreg <= load_val;
      left <= CW'(W);
    end else if (shift && (left != '0)) begin
      sreg <= sreg >> 1;
      left <= left - 1'b1;
    end
  end

  // a drained register presents zero
  assign head = (left != '0) ? sreg[0] : 1'b0;

  // R6
  load_full_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (left == CW'(W)));

  // R6
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !shift) |=> ($stable(sreg) && $stable(left)));
endmodule

// File: rtl/trig_busy_serializer.sv
module trig_busy_serializer #(
  parameter int NUM_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_req,
  input  logic readout_en,
  input  logic busy_in,
  input  logic dclk_in,
  output logic trig_line,
  output logic veto
);
  import tbh_pkg::*;

  hs_state_t        state;
  logic [NUM_W-1:0] trig_count;
  logic [NUM_W-1:0] next_num;
  logic             mode_lat;
  logic             busy_s;
  logic             dclk_tog;
  logic             accept;
  logic             do_shift;
  logic             bit_head;

  tbh_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
    .clk (clk),
    .rst (rst),
    .d   (busy_in),
    .q   (busy_s)
  );

  tbh_toggle_det #(.STAGES(SYNC_STAGES)) u_dclk_det (
    .clk      (clk),
    .rst      (rst),
    .async_in (dclk_in),
    .toggle   (dclk_tog)
  );

  assign next_num = trig_count + 1'b1;
  assign accept   = trig_req && !veto && (state == ST_IDLE);
  assign do_shift = (state == ST_HOLD) && busy_s && mode_lat && dclk_tog;

  tbh_shifter #(.W(NUM_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (next_num),
    .shift    (do_shift),
    .head     (bit_head)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      trig_line  <= 1'b0;
      veto       <= 1'b0;
      trig_count <= '0;
      mode_lat   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state      <= ST_RAISED;
            trig_line  <= 1'b1;
            veto       <= 1'b1;
            trig_count <= next_num;
            mode_lat   <= readout_en;
          end
        end
        ST_RAISED: begin
          if (busy_s) begin
            state     <= ST_HOLD;
            trig_line <= 1'b0;
          end
        end
        ST_HOLD: begin
          if (!busy_s) begin
            state     <= ST_IDLE;
            trig_line <= 1'b0;
            veto      <= 1'b0;
          end else if (do_shift) begin
            trig_line <= bit_head;
          end
        end
        default: begin
          state     <= ST_IDLE;
          trig_line <= 1'b0;
          veto      <= 1'b0;
        end
      endcase
    end
  end

  // R2
  accept_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (trig_req && !veto) |=> (trig_line && veto));

  // R3
  count_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    veto |=> $stable(trig_count));

  // R4
  raised_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RAISED && !busy_s) |=> trig_line);

  // R4
  plain_low_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && !mode_lat) |-> !trig_line);

  // R5
  veto_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (veto && busy_s) |=> veto);

  // R10
  mode_stable_chk: assert property (@(posedge clk) disable iff (rst)
    veto |=> $stable(mode_lat));
endmodule

// File: tb/trig_busy_serializer_test.sv
module trig_busy_serializer_test;
  localparam int CLK_P = 10;
  localparam int NUM_W = 32;
  localparam int SETTLE = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig_req = 1'b0;
  logic readout_en = 1'b0;
  logic busy_in = 1'b0;
  logic dclk_in = 1'b0;
  logic trig_line;
  logic veto;

  int total = 0;
  int bad = 0;
  logic [NUM_W-1:0] exp_num = '0;

  always #(CLK_P/2) clk = ~clk;

  trig_busy_serializer #(.NUM_W(NUM_W), .SYNC_STAGES(2)) uut (
    .clk        (clk),
    .rst        (rst),
    .trig_req   (trig_req),
    .readout_en (readout_en),
    .busy_in    (busy_in),
    .dclk_in    (dclk_in),
    .trig_line  (trig_line),
    .veto       (veto)
  );

  task automatic chk(input string req, input logic [NUM_W-1:0] act, input logic [NUM_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic fire(input logic mode);
    @(negedge clk);
    readout_en = mode;
    trig_req = 1'b1;
    @(negedge clk);
    trig_req = 1'b0;
    exp_num = exp_num + 1'b1;
    chk("R2 trig_line raised", {31'd0, trig_line}, 1);
    chk("R2 veto raised", {31'd0, veto}, 1);
  endtask

  task automatic raise_busy();
    busy_in = 1'b1;
    wait_settle();
    chk("R4 trig_line low after busy", {31'd0, trig_line}, 0);
    chk("R5 veto held while busy", {31'd0, veto}, 1);
  endtask

  task automatic drop_busy();
    busy_in = 1'b0;
    wait_settle();
    chk("R5 veto released", {31'd0, veto}, 0);
    chk("R5 trig_line low when idle", {31'd0, trig_line}, 0);
  endtask

  task automatic read_bits(input int n, output logic [NUM_W-1:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      dclk_in = ~dclk_in;
      wait_settle();
      got[i] = trig_line;
    end
  endtask

  task automatic t_reset();
    chk("R1 trig_line after reset", {31'd0, trig_line}, 0);
    chk("R1 veto after reset", {31'd0, veto}, 0);
  endtask

  task automatic t_plain();
    fire(1'b0);
    repeat (4) @(negedge clk);
    chk("R4 trig_line held before busy", {31'd0, trig_line}, 1);
    raise_busy();
    for (int i = 0; i < 4; i++) begin
      dclk_in = ~dclk_in;
      wait_settle();
      chk("R4 plain mode stays low on dclk", {31'd0, trig_line}, 0);
    end
    drop_busy();
  endtask

  task automatic t_full_readout();
    logic [NUM_W-1:0] got;
    logic [NUM_W-1:0] extra;
    // R1 R7: first accepted trigger is number 1, second is 2
    fire(1'b1);
    raise_busy();
    read_bits(NUM_W, got);
    chk("R7 number of trigger", got, exp_num);
    read_bits(3, extra);
    chk("R8 extra toggles give zero", extra, 0);
    drop_busy();
  endtask

  task automatic t_veto_ignore();
    logic [NUM_W-1:0] got;
    fire(1'b1);
    @(negedge clk);
    trig_req = 1'b1;
    @(negedge clk);
    trig_req = 1'b0;
    chk("R3 trig_line unchanged by vetoed request", {31'd0, trig_line}, 1);
    // R9: toggle while trig_line still high
    dclk_in = ~dclk_in;
    wait_settle();
    chk("R9 trig_line still high after early dclk", {31'd0, trig_line}, 1);
    raise_busy();
    trig_req = 1'b1;
    @(negedge clk);
    trig_req = 1'b0;
    wait_settle();
    chk("R3 request in busy phase ignored", {31'd0, trig_line}, 0);
    read_bits(NUM_W, got);
    chk("R3 R9 number unchanged and starts at bit 0", got, exp_num);
    drop_busy();
  endtask

  task automatic t_mode_change();
    logic [NUM_W-1:0] got;
    fire(1'b0);
    readout_en = 1'b1;
    raise_busy();
    read_bits(8, got);
    chk("R10 mode flip to readout ignored", got, 0);
    drop_busy();
    fire(1'b1);
    readout_en = 1'b0;
    raise_busy();
    read_bits(NUM_W, got);
    chk("R10 mode flip to plain ignored", got, exp_num);
    drop_busy();
  endtask

  task automatic t_abort();
    logic [NUM_W-1:0] got;
    // bring the number to a value with several low bits set
    while (exp_num[2:0] != 3'b110) begin
      fire(1'b0);
      raise_busy();
      drop_busy();
    end
    fire(1'b1);
    raise_busy();
    read_bits(2, got);
    chk("R6 first two bits LSB first", got, {30'd0, exp_num[1:0]});
    drop_busy();
    fire(1'b1);
    raise_busy();
    read_bits(NUM_W, got);
    chk("R11 fresh readout after abort", got, exp_num);
    drop_busy();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_plain();
    t_full_readout();
    t_veto_ignore();
    t_mode_change();
    t_abort();
    // R1: reset mid-handshake then restart numbering
    fire(1'b1);
    @(negedge clk);
    rst = 1'b1;
    busy_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_num = '0;
    @(negedge clk);
    t_reset();
    t_full_readout();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule